// File: doc/BRIEF.md
# Mapping Replay Scanner

The scanner walks the address window of a page translation table and announces every page that currently holds a mapping. After a start pulse it latches the page size exponent and the entry count. It then steps an address from zero in page-sized increments and asks the table about each page through a lookup port. The lookup port has a request handshake and a separate response strobe. Every response whose permission code is not the fault code is passed downstream as one notification on a valid/ready port. Each notification carries the page address, the translated page base, the permission and the in-page offset mask.

A skip input given with the start pulse turns the scan into a no-op that only reports completion. The walk ends when the next address would leave the window, whose size is the entry count shifted left by the page exponent. It also ends when adding the step would carry past the top of the address width. A single-cycle done pulse marks the end of every scan. The block keeps only one lookup in flight, and it stalls for as long as the notification consumer holds ready low.

Top module: `map_replay_scan`

## Requirements
- R1: When start_i is high together with skip_i, done_o is high in the next cycle, and that scan issues no lookup and no notification.
- R2: Lookup addresses begin at 0 and increase by exactly 2^page_shift per step, where page_shift is sampled at start.
- R3: Only addresses below entry_count << page_shift are looked up. An entry count of 0 gives no lookups and a done pulse.
- R4: A response with permission code 2'b00 (fault) produces no notification. Codes 2'b01, 2'b10 and 2'b11 each produce exactly one notification.
- R5: A notification carries iova equal to the looked-up address, xlat equal to the response address with the low page_shift bits cleared, the response permission, and mask equal to 2^page_shift - 1. The mask is all ones when page_shift is at least the address width.
- R6: If the current address plus the step reaches 2^ADDR_W, the scan ends after that page, even when the window extends further.
- R7: While nt_valid_o is high and nt_ready_i is low, the notification stays valid and unchanged.
- R8: At most one lookup is outstanding. A request that is not accepted stays asserted with the same address.
- R9: done_o is a single-cycle pulse, given once per scan. A start pulse during a running scan is ignored.
- R10: Notifications appear in strictly ascending address order within a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| skip_i | input | 1 | With start_i: finish without scanning |
| page_shift_i | input | SHIFT_W | Page size exponent, sampled at start |
| entry_count_i | input | CNT_W | Number of table entries, sampled at start |
| lk_valid_o | output | 1 | Lookup request valid |
| lk_ready_i | input | 1 | Lookup request accepted |
| lk_addr_o | output | ADDR_W | Address being looked up |
| rsp_valid_i | input | 1 | Lookup response strobe |
| rsp_perm_i | input | 2 | Permission code of the response |
| rsp_xlat_i | input | ADDR_W | Translated address of the response |
| nt_valid_o | output | 1 | Notification valid |
| nt_ready_i | input | 1 | Notification accepted |
| nt_iova_o | output | ADDR_W | Page address of the notification |
| nt_xlat_o | output | ADDR_W | Translated page base |
| nt_perm_o | output | 2 | Permission code |
| nt_mask_o | output | ADDR_W | In-page offset mask |
| done_o | output | 1 | Scan finished (one-cycle pulse) |

## Verification
The two end conditions of the walk, window exhaustion and address wrap-around, can fall on the same step. That step is where one termination path could mask the other or fire twice. A window of exactly 2^ADDR_W, with 16 entries of 4 KiB pages, drives both to trigger after page 61440. The bench judges the scan by an exact list of 16 lookups and a single done pulse. A separate wide-page case, with 255 entries of 32 KiB pages, isolates the wrap stop alone. A start pulse landing mid-scan is also provoked, and must leave the running scan's lookup sequence intact.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_NOTE,
        ST_DONE
    } scan_state_e;

    localparam int PERM_W = 2;
    localparam logic [PERM_W-1:0] PERM_FAULT = 2'b00;

endpackage

// File: rtl/mrs_geometry.sv
module mrs_geometry #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int SHIFT_W = 4
) (
    input  logic [SHIFT_W-1:0] shift_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [ADDR_W-1:0]  next_addr_o,
    output logic [ADDR_W-1:0]  mask_o,
    output logic               last_o
);
    // Wide enough to hold the full window without loss.
    localparam int WIN_W = CNT_W + (1 << SHIFT_W) + 1;

    logic [WIN_W-1:0] step_w;
    logic [WIN_W-1:0] window_w;
    logic [WIN_W-1:0] sum_w;
    logic             wrap;

    always_comb begin
        step_w      = WIN_W'(1) << shift_i;
        window_w    = WIN_W'(count_i) << shift_i;
        sum_w       = WIN_W'(addr_i) + step_w;
        wrap        = |sum_w[WIN_W-1:ADDR_W];
        last_o      = wrap || (sum_w >= window_w);
        next_addr_o = sum_w[ADDR_W-1:0];
        mask_o      = ADDR_W'(step_w - WIN_W'(1));
    end

endmodule

// File: rtl/mrs_perm_decode.sv
module mrs_perm_decode
    import mrs_pkg::*;
(
    input  logic [PERM_W-1:0] perm_i,
    output logic              mapped_o
);
    always_comb begin
        mapped_o = (perm_i != PERM_FAULT);
    end

endmodule

// File: rtl/map_replay_scan.sv
module map_replay_scan
    import mrs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               skip_i,
    input  logic [SHIFT_W-1:0] page_shift_i,
    input  logic [CNT_W-1:0]   entry_count_i,
    output logic               lk_valid_o,
    input  logic               lk_ready_i,
    output logic [ADDR_W-1:0]  lk_addr_o,
    input  logic               rsp_valid_i,
    input  logic [1:0]         rsp_perm_i,
    input  logic [ADDR_W-1:0]  rsp_xlat_i,
    output logic               nt_valid_o,
    input  logic               nt_ready_i,
    output logic [ADDR_W-1:0]  nt_iova_o,
    output logic [ADDR_W-1:0]  nt_xlat_o,
    output logic [1:0]         nt_perm_o,
    output logic [ADDR_W-1:0]  nt_mask_o,
    output logic               done_o
);

    typedef struct packed {
        scan_state_e        state;
        logic [ADDR_W-1:0]  addr;
        logic [SHIFT_W-1:0] shift;
        logic [CNT_W-1:0]   count;
        logic [ADDR_W-1:0]  xlat;
        logic [PERM_W-1:0]  perm;
    } scan_regs_t;

    scan_regs_t q, d;

    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] page_mask;
    logic              last_page;
    logic              mapped;

    mrs_geometry #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SHIFT_W(SHIFT_W)
    ) u_geometry (
        .shift_i    (q.shift),
        .count_i    (q.count),
        .addr_i     (q.addr),
        .next_addr_o(next_addr),
        .mask_o     (page_mask),
        .last_o     (last_page)
    );

    mrs_perm_decode u_perm (
        .perm_i  (rsp_perm_i),
        .mapped_o(mapped)
    );

    // State that follows the current page: either the next request or the end.
    scan_state_e adv_state;
    always_comb begin
        adv_state = last_page ? ST_DONE : ST_REQ;
    end

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (skip_i) begin
                        d.state = ST_DONE;
                    end else begin
                        d.shift = page_shift_i;
                        d.count = entry_count_i;
                        d.addr  = '0;
                        d.state = (entry_count_i == '0) ? ST_DONE : ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (lk_ready_i) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (mapped) begin
                        d.xlat  = rsp_xlat_i & ~page_mask;
                        d.perm  = rsp_perm_i;
                        d.state = ST_NOTE;
                    end else begin
                        d.state = adv_state;
                        if (!last_page) begin
                            d.addr = next_addr;
                        end
                    end
                end
            end
            ST_NOTE: begin
                if (nt_ready_i) begin
                    d.state = adv_state;
                    if (!last_page) begin
                        d.addr = next_addr;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, addr: '0, shift: '0, count: '0,
                   xlat: '0, perm: PERM_FAULT};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        lk_valid_o = (q.state == ST_REQ);
        lk_addr_o  = q.addr;
        nt_valid_o = (q.state == ST_NOTE);
        nt_iova_o  = q.addr;
        nt_xlat_o  = q.xlat;
        nt_perm_o  = q.perm;
        nt_mask_o  = page_mask;
        done_o     = (q.state == ST_DONE);
    end

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_ready,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              nt_valid,
    input logic              nt_ready,
    input logic [ADDR_W-1:0] nt_iova,
    input logic [ADDR_W-1:0] nt_xlat,
    input logic [1:0]        nt_perm,
    input logic [ADDR_W-1:0] nt_mask,
    input logic              done
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
        end else if (nt_valid && nt_ready) begin
            seen_q <= 1'b1;
            last_q <= nt_iova;
        end
    end

    p_lookup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_addr)));

    p_note_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && !nt_ready) |=> (nt_valid && $stable(nt_iova)
                                     && $stable(nt_xlat) && $stable(nt_perm)));

    p_mapped_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nt_valid |-> (nt_perm != 2'b00));

    p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nt_valid |-> (((nt_iova & nt_mask) == '0) && ((nt_xlat & nt_mask) == '0)));

    p_one_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_valid, nt_valid, done}));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ascending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && seen_q) |-> (nt_iova > last_q));

endmodule

bind map_replay_scan mrs_checker #(.ADDR_W(ADDR_W)) u_mrs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_valid(lk_valid_o),
    .lk_ready(lk_ready_i),
    .lk_addr (lk_addr_o),
    .nt_valid(nt_valid_o),
    .nt_ready(nt_ready_i),
    .nt_iova (nt_iova_o),
    .nt_xlat (nt_xlat_o),
    .nt_perm (nt_perm_o),
    .nt_mask (nt_mask_o),
    .done    (done_o)
);

// File: tb/test_map_replay_scan.sv
module test_map_replay_scan;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, skip = 1'b0;
    logic [SW-1:0] shift = '0;
    logic [CW-1:0] count = '0;
    logic          lk_valid, lk_ready = 1'b0;
    logic [AW-1:0] lk_addr;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_perm = '0;
    logic [AW-1:0] rsp_xlat = '0;
    logic          nt_valid, nt_ready = 1'b0;
    logic [AW-1:0] nt_iova, nt_xlat, nt_mask;
    logic [1:0]    nt_perm;
    logic          done;

    always #5 clk = ~clk;

    map_replay_scan #(.ADDR_W(AW), .CNT_W(CW), .SHIFT_W(SW)) i_map_replay_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start), .skip_i(skip),
        .page_shift_i(shift), .entry_count_i(count),
        .lk_valid_o(lk_valid), .lk_ready_i(lk_ready), .lk_addr_o(lk_addr),
        .rsp_valid_i(rsp_valid), .rsp_perm_i(rsp_perm), .rsp_xlat_i(rsp_xlat),
        .nt_valid_o(nt_valid), .nt_ready_i(nt_ready), .nt_iova_o(nt_iova),
        .nt_xlat_o(nt_xlat), .nt_perm_o(nt_perm), .nt_mask_o(nt_mask),
        .done_o(done)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hash(input longint a, input int s);
        return (32'(a) * 32'h9E3779B1) ^ 32'(s * 32'h85EBCA6B);
    endfunction
    function automatic logic [1:0] perm_of(input longint a, input int s);
        logic [31:0] h = hash(a, s);
        return h[17:16];
    endfunction
    function automatic logic [AW-1:0] xlat_of(input longint a, input int s);
        logic [31:0] h = hash(a, s);
        return h[31:16] ^ 16'hA5C3;
    endfunction
    function automatic logic [AW-1:0] mask_of(input int sh);
        return (sh >= AW) ? '1 : AW'((longint'(1) << sh) - 1);
    endfunction

    longint exp_lk[0:299];
    longint exp_nt[0:299];
    int     n_lk_exp, n_nt_exp, salt, cur_sh;
    int     lk_n, nt_n, done_n;
    bit     stall_mode = 1'b0;
    bit     pend = 1'b0;
    int     dly = 0;
    longint paddr = 0;
    bit     p_ntv = 0, p_ntr = 0, p_lkv = 0, p_lkr = 0;
    logic [AW-1:0] p_iova = '0, p_lka = '0;
    int     cyc = 0;

    // Expected walk from R2, R3, R4, R6
    task automatic plan_scan(input int sh, input int cnt);
        longint step = longint'(1) << sh;
        longint win  = longint'(cnt) << sh;
        longint a = 0;
        n_lk_exp = 0;
        n_nt_exp = 0;
        while (a < win) begin
            exp_lk[n_lk_exp++] = a;
            if (perm_of(a, salt) != 2'b00) exp_nt[n_nt_exp++] = a;
            if (a + step >= (longint'(1) << AW)) break;
            a += step;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ntv && !p_ntr)
                check(nt_valid && nt_iova == p_iova, "R7 held notification", nt_iova, p_iova);
            if (p_lkv && !p_lkr)
                check(lk_valid && lk_addr == p_lka, "R8 held lookup", lk_addr, p_lka);
            if (done) done_n++;
            rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    rsp_valid = 1'b1;
                    rsp_perm  = perm_of(paddr, salt);
                    rsp_xlat  = xlat_of(paddr, salt);
                    pend = 1'b0;
                end else dly--;
            end
            lk_ready = ($urandom % 3) != 0;
            if (lk_valid && lk_ready) begin
                if (lk_n < n_lk_exp)
                    check(lk_addr == AW'(exp_lk[lk_n]), "R2 lookup address", lk_addr, exp_lk[lk_n]);
                else
                    check(1'b0, "R3 R6 lookup beyond walk", lk_addr, 0);
                lk_n++;
                pend  = 1'b1;
                paddr = lk_addr;
                dly   = $urandom % 3;
            end
            nt_ready = stall_mode ? (($urandom % 16) == 0) : (($urandom % 4) != 0);
            if (nt_valid && nt_ready) begin
                if (nt_n < n_nt_exp) begin
                    check(nt_iova == AW'(exp_nt[nt_n]), "R4 R10 notification order", nt_iova, exp_nt[nt_n]);
                    check(nt_xlat == (xlat_of(exp_nt[nt_n], salt) & ~mask_of(cur_sh)), "R5 xlat",
                          nt_xlat, xlat_of(exp_nt[nt_n], salt) & ~mask_of(cur_sh));
                    check(nt_perm == perm_of(exp_nt[nt_n], salt), "R5 perm", nt_perm, perm_of(exp_nt[nt_n], salt));
                    check(nt_mask == mask_of(cur_sh), "R5 mask", nt_mask, mask_of(cur_sh));
                end else
                    check(1'b0, "R4 extra notification", nt_iova, 0);
                nt_n++;
            end
            p_ntv = nt_valid; p_ntr = nt_ready; p_iova = nt_iova;
            p_lkv = lk_valid; p_lkr = lk_ready; p_lka = lk_addr;
        end
    end

    task automatic run_scan(input int sh, input int cnt, input bit skp, input bit mid, input string tag);
        int t = 0;
        salt   = int'($urandom);
        cur_sh = sh;
        if (skp) begin n_lk_exp = 0; n_nt_exp = 0; end
        else plan_scan(sh, cnt);
        lk_n = 0; nt_n = 0; done_n = 0;
        start = 1'b1; skip = skp; shift = SW'(sh); count = CW'(cnt);
        @(negedge clk);
        start = 1'b0; skip = 1'b0;
        if (skp) check(done == 1'b1, "R1 done next cycle", done, 1);
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (mid && t == 4) begin
                start = 1'b1; shift = 4'd3; count = 8'd5;
            end else start = 1'b0;
        end
        start = 1'b0;
        check(t < 20000, {tag, " scan finished"}, t, 0);
        repeat (3) @(negedge clk);
        check(lk_n == n_lk_exp, {tag, " lookup count"}, lk_n, n_lk_exp);
        check(nt_n == n_nt_exp, {tag, " notification count"}, nt_n, n_nt_exp);
        check(done_n == 1, "R9 single done pulse", done_n, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!lk_valid && !nt_valid && !done, "R9 reset idle", {lk_valid, nt_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_scan(12, 200, 1'b1, 1'b0, "R1");
        run_scan(12, 16, 1'b0, 1'b0, "R3 R6 coincident end");
        run_scan(15, 255, 1'b0, 1'b0, "R6 wrap");
        run_scan(15, 1, 1'b0, 1'b0, "R3 single page");
        run_scan(5, 0, 1'b0, 1'b0, "R3 empty");
        run_scan(0, 20, 1'b0, 1'b0, "R2 byte pages");
        stall_mode = 1'b1;
        run_scan(8, 40, 1'b0, 1'b0, "R7 stall");
        stall_mode = 1'b0;
        run_scan(10, 60, 1'b0, 1'b1, "R9 start ignored");
        for (int i = 0; i < 12; i++)
            run_scan(int'($urandom % 16), int'($urandom % 256), 1'b0, 1'b0, "R2 R3 random");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule